// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the column address sequence of a synchronous DRAM burst. A small mode register holds a burst length code, a burst-order bit and a write-single bit. When a read, write or block-write command arrives, the block takes the command's starting column and issues one column address per clock on a registered output. A valid flag and a final-beat flag come with each address.

A running burst can end early in three ways. A stop command ends a full-page burst. A precharge ends a burst of any length. A new column command cuts the current burst off and starts its own. When a burst was opened with auto-precharge, the block refuses new-command and precharge interrupts until that burst has issued its final beat. It pulses a reject flag for each refused command.

Top module: `burst_colgen`

## Requirements
- R1: After reset the outputs are idle (valid, last and reject low) and the mode holds length code 000 with sequential order and write-single off. A mode load changes the mode from the next clock. Length codes are 000=1, 001=2, 010=4, 011=8 and 111=full page; codes 100 to 110 behave as length 1.
- R2: A column command is sampled on a clock edge, and the start column appears on `col_addr` with `col_valid` high right after that edge. Each further edge issues the next beat.
- R3: With the order bit at 0 and length 2, 4 or 8, beat k has its low 1, 2 or 3 bits equal to (start + k) modulo the length. The upper bits keep the start value.
- R4: With the order bit at 1 and length 2, 4 or 8, beat k has its low bits equal to start XOR k, with the upper bits fixed. At length 1 or 2 this gives the same sequence as order 0. Full page ignores the order bit.
- R5: A full-page burst adds one to the column on each beat, and column 255 is followed by 0. It runs until a stop, a precharge or a new command ends it, and `col_last` is never raised in it.
- R6: `col_last` is high on the final beat of a fixed-length burst only. If no command arrives on that edge, `col_valid` falls at the next edge.
- R7: Stop (op 4) during a full-page burst leaves `col_valid` low from the next edge on. At any other length, stop is ignored and the burst continues.
- R8: With write-single set, a write (op 2) issues one beat with `col_last` high, while a read (op 1) keeps the programmed length.
- R9: A block write (op 3) issues a single beat, with the low 3 column bits forced to 0 and `col_last` high.
- R10: A read, write or block-write command (ops 1, 2, 3) that arrives during a burst ends that burst and issues its own start column right after its edge. Such commands may arrive on consecutive clocks.
- R11: A precharge (op 5) during a burst ends it. `col_valid` is low after that edge.
- R12: While a burst opened with `cmd_ap` high still has beats to issue, a column command or precharge is refused. `irq_reject` pulses high for one clock after the refused command's edge, and the burst goes on. A command that arrives on the final beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_ld | input | 1 | Load the mode register |
| mode_len | input | 3 | Burst length code |
| mode_ilv | input | 1 | Order: 0 sequential, 1 interleave |
| mode_wr1 | input | 1 | Force write bursts to one beat |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | 1 read, 2 write, 3 block write, 4 stop, 5 precharge |
| cmd_col | input | COL_W | Starting column |
| cmd_ap | input | 1 | Command carries auto-precharge |
| col_addr | output | COL_W | Column of the current beat |
| col_valid | output | 1 | Beat present |
| col_last | output | 1 | Final beat of a fixed-length burst |
| irq_reject | output | 1 | Interrupt refused under auto-precharge |

## Verification
The assertions check four things on every cycle: a final-beat flag never appears without a valid beat, a full-page beat always steps by one (wrapping at the page end), an accepted stop or precharge leaves the output idle, and a refused interrupt leaves the burst running. The assertions also check that block-write beats are aligned and single, and that a mode load takes effect. Only the bench's directed scenarios show the complete order of each sequential and interleaved burst. They also show that stop is ignored at fixed lengths, that the write-single bit leaves reads alone, and that back-to-back commands and a command on the final beat are accepted.

// File: rtl/bcg_pkg.sv
package bcg_pkg;
  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_RD   = 3'd1,
    OP_WR   = 3'd2,
    OP_BW   = 3'd3,
    OP_STOP = 3'd4,
    OP_PRE  = 3'd5
  } op_e;

  localparam logic [2:0] LEN_FULL = 3'b111;
  localparam logic [2:0] LEN_ONE  = 3'b000;

  // number of low column bits that wrap inside a fixed-length burst
  function automatic int unsigned len_bits(input logic [2:0] code);
    case (code)
      3'b001:  return 1;
      3'b010:  return 2;
      3'b011:  return 3;
      default: return 0;
    endcase
  endfunction
endpackage

// File: rtl/bcg_mode.sv
module bcg_mode (
  input  logic       clk,
  input  logic       rst,
  input  logic       ld,
  input  logic [2:0] len_i,
  input  logic       ilv_i,
  input  logic       wr1_i,
  output logic [2:0] len_o,
  output logic       ilv_o,
  output logic       wr1_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      len_o <= 3'b000;
      ilv_o <= 1'b0;
      wr1_o <= 1'b0;
    end else if (ld) begin
      len_o <= len_i;
      ilv_o <= ilv_i;
      wr1_o <= wr1_i;
    end
  end

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (rst)
    ld |=> (len_o == $past(len_i)) && (ilv_o == $past(ilv_i))); // R1
endmodule

// File: rtl/bcg_addr.sv
module bcg_addr import bcg_pkg::*; #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] start,
  input  logic [COL_W-1:0] beat,
  input  logic [2:0]       len,
  input  logic             ilv,
  output logic [COL_W-1:0] addr
);
  logic [COL_W-1:0] mask;
  logic [COL_W-1:0] sum;

  always_comb begin
    mask = ~({COL_W{1'b1}} << len_bits(len));
    sum  = start + beat;
    if (len == LEN_FULL)
      addr = sum;
    else if (ilv)
      addr = (start & ~mask) | ((start ^ beat) & mask);
    else
      addr = (start & ~mask) | (sum & mask);
  end
endmodule

// File: rtl/bcg_ctrl.sv
module bcg_ctrl import bcg_pkg::*; #(
  parameter int COL_W   = 8,
  parameter int BW_BITS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       len_i,
  input  logic             ilv_i,
  input  logic             wr1_i,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cmd_ap,
  output logic [COL_W-1:0] col_q,
  output logic             vld_q,
  output logic             last_q,
  output logic             rej_q
);
  localparam logic [COL_W-1:0] BW_KEEP = {COL_W{1'b1}} << BW_BITS;

  op_e              op;
  logic             is_col, busy, rej, start, pre_acc, stop_acc, advance;
  logic [2:0]       new_len;
  logic [COL_W-1:0] new_col, cnt_nx, nxt_addr, cur_mask;
  logic             new_full;

  logic [COL_W-1:0] start_q, cnt_q;
  logic [2:0]       len_q;
  logic             ilv_q, full_q, ap_q;

  bcg_addr #(.COL_W(COL_W)) u_addr (
    .start (start_q),
    .beat  (cnt_nx),
    .len   (len_q),
    .ilv   (ilv_q),
    .addr  (nxt_addr)
  );

  always_comb begin
    op       = op_e'(cmd_op);
    is_col   = cmd_valid && (op == OP_RD || op == OP_WR || op == OP_BW);
    busy     = vld_q && !last_q;
    rej      = busy && ap_q && cmd_valid && (is_col || op == OP_PRE);
    start    = is_col && !rej;
    pre_acc  = busy && cmd_valid && (op == OP_PRE) && !rej;
    stop_acc = busy && cmd_valid && (op == OP_STOP) && full_q;
    advance  = busy && !start && !pre_acc && !stop_acc;
    new_len  = (op == OP_BW || (op == OP_WR && wr1_i)) ? LEN_ONE : len_i;
    new_col  = (op == OP_BW) ? (cmd_col & BW_KEEP) : cmd_col;
    new_full = (new_len == LEN_FULL);
    cnt_nx   = cnt_q + 1'b1;
    cur_mask = ~({COL_W{1'b1}} << len_bits(len_q));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      col_q   <= '0;
      cnt_q   <= '0;
      len_q   <= LEN_ONE;
      ilv_q   <= 1'b0;
      full_q  <= 1'b0;
      ap_q    <= 1'b0;
      vld_q   <= 1'b0;
      last_q  <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      rej_q <= rej;
      if (start) begin
        start_q <= new_col;
        col_q   <= new_col;
        cnt_q   <= '0;
        len_q   <= new_len;
        ilv_q   <= ilv_i;
        full_q  <= new_full;
        ap_q    <= cmd_ap;
        vld_q   <= 1'b1;
        last_q  <= !new_full && (len_bits(new_len) == 0);
      end else if (advance) begin
        cnt_q  <= cnt_nx;
        col_q  <= nxt_addr;
        last_q <= !full_q && (cnt_nx == cur_mask);
      end else begin
        vld_q  <= 1'b0;
        last_q <= 1'b0;
      end
    end
  end

  AST_LAST_VALID: assert property (@(posedge clk) disable iff (rst)
    last_q |-> vld_q); // R6
  AST_BW_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (start && op == OP_BW) |=> (col_q[BW_BITS-1:0] == '0) && last_q); // R9
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (rst)
    stop_acc |=> !vld_q); // R7
  AST_PRE_IDLE: assert property (@(posedge clk) disable iff (rst)
    pre_acc |=> !vld_q); // R11
  AST_PAGE_STEP: assert property (@(posedge clk) disable iff (rst)
    (advance && full_q) |=> vld_q && !last_q && (col_q == COL_W'($past(col_q) + 1'b1))); // R5
  AST_REJ_KEEP: assert property (@(posedge clk) disable iff (rst)
    rej |=> vld_q && rej_q); // R12
endmodule

// File: rtl/burst_colgen.sv
module burst_colgen #(
  parameter int COL_W   = 8,
  parameter int BW_BITS = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_ld,
  input  logic [2:0]       mode_len,
  input  logic             mode_ilv,
  input  logic             mode_wr1,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd_op,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             cmd_ap,
  output logic [COL_W-1:0] col_addr,
  output logic             col_valid,
  output logic             col_last,
  output logic             irq_reject
);
  logic [2:0] len_m;
  logic       ilv_m, wr1_m;

  bcg_mode u_mode (
    .clk   (clk),
    .rst   (rst),
    .ld    (mode_ld),
    .len_i (mode_len),
    .ilv_i (mode_ilv),
    .wr1_i (mode_wr1),
    .len_o (len_m),
    .ilv_o (ilv_m),
    .wr1_o (wr1_m)
  );

  bcg_ctrl #(.COL_W(COL_W), .BW_BITS(BW_BITS)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .len_i     (len_m),
    .ilv_i     (ilv_m),
    .wr1_i     (wr1_m),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_col   (cmd_col),
    .cmd_ap    (cmd_ap),
    .col_q     (col_addr),
    .vld_q     (col_valid),
    .last_q    (col_last),
    .rej_q     (irq_reject)
  );
endmodule

// File: tb/burst_colgen_tb.sv
module burst_colgen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_ld = 1'b0;
  logic [2:0] mode_len = 3'b000;
  logic       mode_ilv = 1'b0, mode_wr1 = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_col = 8'd0;
  logic       cmd_ap = 1'b0;
  logic [7:0] col_addr;
  logic       col_valid, col_last, irq_reject;
  int total = 0, bad = 0;
  bit done = 0;

  burst_colgen u_dut (.*);

  always #5 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic beat(string tag, int col, bit last);
    chk({tag, " valid"}, int'(col_valid), 1);
    chk({tag, " col"}, int'(col_addr), col);
    chk({tag, " last"}, int'(col_last), int'(last));
  endtask

  task automatic idle(string tag);
    chk({tag, " idle"}, int'(col_valid), 0);
  endtask

  task automatic set_mode(logic [2:0] len, bit ilv, bit wr1);
    @(negedge clk);
    mode_ld = 1; mode_len = len; mode_ilv = ilv; mode_wr1 = wr1;
    @(posedge clk); #1;
    mode_ld = 0;
  endtask

  task automatic issue(logic [2:0] op, logic [7:0] col, bit ap);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_col = col; cmd_ap = ap;
    @(posedge clk); #1;
    cmd_valid = 0; cmd_op = 0; cmd_ap = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    chk("R1 reset valid", int'(col_valid), 0);
    chk("R1 reset last", int'(col_last), 0);
    chk("R1 reset reject", int'(irq_reject), 0);
    issue(3'd1, 8'h44, 0);  // default mode: one beat
    beat("R1 default len1", 8'h44, 1);
    step(); idle("R6 after len1");
  endtask

  task automatic t_seq8();
    set_mode(3'b011, 0, 0);
    issue(3'd1, 8'h15, 0);
    for (int k = 0; k < 8; k++) begin
      if (k > 0) step();
      beat("R2 R3 seq8", 8'h10 | ((5 + k) % 8), k == 7);
    end
    step(); idle("R6 seq8 end");
  endtask

  task automatic t_ilv();
    set_mode(3'b011, 1, 0);
    issue(3'd1, 8'h15, 0);
    for (int k = 0; k < 8; k++) begin
      if (k > 0) step();
      beat("R4 ilv8", 8'h10 | (5 ^ k), k == 7);
    end
    set_mode(3'b010, 1, 0);
    issue(3'd1, 8'h06, 0);
    beat("R4 ilv4 b0", 8'h06, 0); step();
    beat("R4 ilv4 b1", 8'h07, 0); step();
    beat("R4 ilv4 b2", 8'h04, 0); step();
    beat("R4 ilv4 b3", 8'h05, 1);
    set_mode(3'b001, 1, 0);
    issue(3'd1, 8'h23, 0);
    beat("R4 ilv2 b0", 8'h23, 0); step();
    beat("R4 ilv2 b1", 8'h22, 1);
    set_mode(3'b001, 0, 0);
    issue(3'd1, 8'h23, 0);
    beat("R3 seq2 b0", 8'h23, 0); step();
    beat("R3 seq2 b1", 8'h22, 1);
    step(); idle("R6 len2 end");
  endtask

  task automatic t_full();
    set_mode(3'b111, 1, 0);
    issue(3'd1, 8'hFD, 0);
    for (int k = 0; k < 5; k++) begin
      if (k > 0) step();
      beat("R5 full wrap", (8'hFD + k) % 256, 0);
    end
    issue(3'd4, 8'h00, 0);
    idle("R7 stop full");
    step(); idle("R7 stop stays idle");
  endtask

  task automatic t_stop_fixed();
    set_mode(3'b010, 0, 0);
    issue(3'd1, 8'h40, 0);
    issue(3'd4, 8'h00, 0);
    beat("R7 stop ignored len4", 8'h41, 0);
  endtask

  task automatic t_wr1();
    set_mode(3'b010, 0, 1);
    issue(3'd2, 8'h30, 0);
    beat("R8 write single", 8'h30, 1);
    step(); idle("R8 write single end");
    issue(3'd1, 8'h30, 0);
    beat("R8 read b0", 8'h30, 0); step(); step(); step();
    beat("R8 read b3", 8'h33, 1);
  endtask

  task automatic t_bw();
    set_mode(3'b011, 0, 0);
    issue(3'd3, 8'h5D, 0);
    beat("R9 block write", 8'h58, 1);
    step(); idle("R9 block write end");
  endtask

  task automatic t_intr();
    set_mode(3'b011, 0, 0);
    issue(3'd1, 8'h00, 0); step(); step();
    beat("R10 before", 8'h02, 0);
    issue(3'd2, 8'h80, 0);
    beat("R10 write cuts in", 8'h80, 0);
    issue(3'd1, 8'h48, 0);
    beat("R10 back to back", 8'h48, 0);
    step();
    beat("R10 continues", 8'h49, 0);
    issue(3'd5, 8'h00, 0);
    idle("R11 precharge");
    step(); idle("R11 stays idle");
  endtask

  task automatic t_ap();
    set_mode(3'b011, 0, 0);
    issue(3'd1, 8'h00, 1);
    issue(3'd1, 8'h80, 0);
    beat("R12 rw refused", 8'h01, 0);
    chk("R12 reject pulse", int'(irq_reject), 1);
    issue(3'd5, 8'h00, 0);
    beat("R12 pre refused", 8'h02, 0);
    chk("R12 reject pre", int'(irq_reject), 1);
    step();
    chk("R12 reject one clock", int'(irq_reject), 0);
    step(); step(); step(); step();
    beat("R12 last beat", 8'h07, 1);
    issue(3'd1, 8'h90, 0);
    beat("R12 accepted on last", 8'h90, 0);
    chk("R12 no reject", int'(irq_reject), 0);
    issue(3'd5, 8'h00, 0);
    idle("R11 pre after ap");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_seq8();
    t_ilv();
    t_full();
    t_stop_fixed();
    t_wr1();
    t_bw();
    t_intr();
    t_ap();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule